// File: doc/BRIEF.md
# Double-Rate Pin Stream Adapter

This block connects a group of general-purpose pins to a pair of valid/ready streams. Each beat on the transmit stream carries the values to drive onto the output pins, one output-enable bit, a capture flag and a small tag. The block registers those values onto the pins and, for beats whose capture flag is set, samples the input pins at the same clock edges where that beat's outputs appear. Each sample returns on the receive stream together with the tag the beat carried.

A parameter selects the mode. In single-rate mode a beat holds one value per pin for a whole clock cycle. In double-rate mode a beat holds a pair per pin: element 0 is driven while the clock is high, and element 1 while it is low. The capture pair is the input seen at the rising edge and at the following falling edge. The capture request and tag travel through a delay line whose length equals the pin register latency (1 or 2 cycles), so every sample is matched to its own beat. A small skid queue absorbs samples still in flight while the receiver stalls. The adapter holds off new capturing beats whenever they could not be absorbed.

Top module: `ddr_pin_streamer`

## Requirements
- R1: A beat accepted at rising edge k drives its outputs starting at edge k. In double-rate mode the pins show element 0 while the clock is high and element 1 during the following low phase. In single-rate mode element 0 is shown for the whole cycle.
- R2: The pin output-enable takes the accepted beat's enable bit at the edge where the beat is accepted.
- R3: While no beat is accepted, the pin values and the output-enable keep their last driven state.
- R4: For a capturing beat accepted at edge k, the returned element 0 equals the input pins at edge k. In double-rate mode element 1 equals the input pins at the falling edge that follows. In single-rate mode element 1 is zero.
- R5: Exactly one receive beat is produced per accepted beat whose capture flag is 1, and none for other beats. Eight beats with the flag alternating 0,1,0,1,... followed by one beat with the flag at 0 give exactly four samples.
- R6: Each sample carries the tag of the beat that requested it, and samples leave in the order their beats were accepted.
- R7: While the receive stream is valid and not ready, its data and tag stay stable and valid stays high. No sample is lost under any stall pattern.
- R8: Transmit ready is low only for a beat whose capture flag is 1 and only when the queued plus in-flight samples fill the skid queue. Beats with the flag at 0 are never stalled.
- R9: While reset is asserted, output-enable, pin outputs and receive valid are all 0. After reset, transmit ready is 1.
- R10: With the pipeline empty and the receiver ready, the receive stream becomes valid right after the rising edge that comes LAT edges after acceptance (LAT = 2 in double-rate mode, 1 in single-rate mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; both edges are used in double-rate mode |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | input | 1 | Transmit beat valid |
| tx_ready | output | 1 | Transmit beat accepted at this edge when valid |
| tx_out0 | input | PIN_OUT_W | Output values for the high phase (or whole cycle) |
| tx_out1 | input | PIN_OUT_W | Output values for the low phase (double-rate only) |
| tx_oe | input | 1 | Output-enable for this beat |
| tx_capture | input | 1 | Request a sample of the input pins for this beat |
| tx_meta | input | META_W | Tag returned with the sample |
| pin_o | output | PIN_OUT_W | Output pin values |
| pin_oe | output | 1 | Output pin enable |
| pin_i | input | PIN_IN_W | Input pin values |
| rx_valid | output | 1 | Receive sample valid |
| rx_ready | input | 1 | Receiver accepts the sample |
| rx_in0 | output | PIN_IN_W | Input value at the rising edge |
| rx_in1 | output | PIN_IN_W | Input value at the falling edge (0 in single-rate mode) |
| rx_meta | output | META_W | Tag of the requesting beat |

## Verification
The assertions check five rules on every cycle: the receive side stays stable under a stall, only capturing beats are ever held off, the enable follows the accepted beat, idle cycles keep the pin state, and the skid queue never takes a sample it has no room for. Only the bench scenarios can show that each sample holds the input seen at exactly the right clock edges, that tags and order survive long random stalls, and that the alternating-flag pattern yields exactly four samples. They also cover the latency in each mode. The input pins change a quarter period after each edge, so a capture that is off by even half a cycle returns a different value.

// File: rtl/pse_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the pin stream adapter.
package pse_pkg;
    // Pin register latency in cycles for the selected data rate.
    function automatic int unsigned pin_latency(input bit ddr);
        return ddr ? 2 : 1;
    endfunction
endpackage

// File: rtl/pse_out_path.sv
`timescale 1ns/1ps
// Output pin register stage.
// Loads a new pin pair and enable when load is high. In double-rate mode
// element 1 is staged and moved into a falling-edge register, and the pin
// selects between the two phases using the clock level.
// Assumes load is only asserted for an accepted beat.
module pse_out_path #(
    parameter int W   = 2,
    parameter bit DDR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d0,
    input  logic [W-1:0] d1,
    input  logic         oe_in,
    output logic [W-1:0] pin_o,
    output logic         pin_oe
);
    logic         oe_q;
    logic [W-1:0] rise_q;

    // Register the enable once on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    oe_q <= 1'b0;
        else if (load) oe_q <= oe_in;
    end

    // Register element 0 on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    rise_q <= '0;
        else if (load) rise_q <= d0;
    end

    assign pin_oe = oe_q;

    generate
        if (DDR) begin : g_ddr
            logic [W-1:0] hold_q;
            logic [W-1:0] fall_q;

            // Stage element 1 on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n)    hold_q <= '0;
                else if (load) hold_q <= d1;
            end

            // Move the staged element 1 into the falling-edge register.
            always_ff @(negedge clk) begin
                if (!rst_n) fall_q <= '0;
                else        fall_q <= hold_q;
            end

            assign pin_o = clk ? rise_q : fall_q;
        end else begin : g_sdr
            logic unused_d1;
            assign unused_d1 = ^d1;
            assign pin_o     = rise_q;
        end
    endgenerate
endmodule

// File: rtl/pse_in_path.sv
`timescale 1ns/1ps
// Input pin capture stage.
// Double-rate mode samples on both edges and re-registers the pair on the
// rising edge so it is aligned to the main clock (2 cycles of latency).
// Single-rate mode samples once on the rising edge (1 cycle of latency).
module pse_in_path #(
    parameter int W   = 8,
    parameter bit DDR = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] cap0,
    output logic [W-1:0] cap1
);
    logic [W-1:0] rise_q;

    // Sample the pins on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= pin_i;
    end

    generate
        if (DDR) begin : g_ddr
            logic [W-1:0] fall_q;
            logic [W-1:0] c0_q;
            logic [W-1:0] c1_q;

            // Sample the pins on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) fall_q <= '0;
                else        fall_q <= pin_i;
            end

            // Re-register both phases together on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c0_q <= '0;
                    c1_q <= '0;
                end else begin
                    c0_q <= rise_q;
                    c1_q <= fall_q;
                end
            end

            assign cap0 = c0_q;
            assign cap1 = c1_q;
        end else begin : g_sdr
            assign cap0 = rise_q;
            assign cap1 = '0;
        end
    endgenerate
endmodule

// File: rtl/pse_req_delay.sv
`timescale 1ns/1ps
// Capture-request delay line.
// Carries the request flag and tag for LAT cycles so that they leave at the
// same time as the sampled pin data. Also reports how many requests are in
// flight, for the credit check at the transmit side.
module pse_req_delay #(
    parameter int MW  = 4,
    parameter int LAT = 2,
    parameter int CW  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_in,
    input  logic [MW-1:0] meta_in,
    output logic          req_out,
    output logic [MW-1:0] meta_out,
    output logic [CW-1:0] inflight
);
    logic [LAT-1:0] v_q;
    logic [MW-1:0]  m_q [LAT];

    generate
        for (genvar s = 0; s < LAT; s++) begin : g_stage
            if (s == 0) begin : g_head
                // Load the first stage from the transmit side.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[0] <= 1'b0;
                        m_q[0] <= '0;
                    end else begin
                        v_q[0] <= req_in;
                        m_q[0] <= meta_in;
                    end
                end
            end else begin : g_body
                // Shift the request one stage further.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        v_q[s] <= 1'b0;
                        m_q[s] <= '0;
                    end else begin
                        v_q[s] <= v_q[s-1];
                        m_q[s] <= m_q[s-1];
                    end
                end
            end
        end
    endgenerate

    assign req_out  = v_q[LAT-1];
    assign meta_out = m_q[LAT-1];
    assign inflight = CW'($countones(v_q));
endmodule

// File: rtl/pse_skid_fifo.sv
`timescale 1ns/1ps
// Small skid queue for returned samples.
// Assumes the writer never pushes when full unless a pop happens in the same
// cycle; the transmit-side credit check guarantees this.
module pse_skid_fifo #(
    parameter int DW    = 20,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          valid,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_pop;

    assign do_pop = pop && valid;

    // Write the pushed entry into storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push) begin
            mem_q[wr_q] <= din;
        end
    end

    // Advance the pointers and the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (push)   wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            count <= count + CW'(push) - CW'(do_pop);
        end
    end

    assign dout  = mem_q[rd_q];
    assign valid = (count != '0);
    assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/ddr_pin_streamer.sv
`timescale 1ns/1ps
// Pin stream adapter, top level.
// Accepts transmit beats, drives them onto the pins and, for capturing beats,
// returns the matching input sample with the beat's tag. The transmit side
// is held off for capturing beats when queued plus in-flight samples would
// exceed the skid queue.
module ddr_pin_streamer #(
    parameter int PIN_OUT_W = 2,
    parameter int PIN_IN_W  = 8,
    parameter int META_W    = 4,
    parameter bit DDR_MODE  = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic [PIN_OUT_W-1:0] tx_out0,
    input  logic [PIN_OUT_W-1:0] tx_out1,
    input  logic                 tx_oe,
    input  logic                 tx_capture,
    input  logic [META_W-1:0]    tx_meta,
    output logic [PIN_OUT_W-1:0] pin_o,
    output logic                 pin_oe,
    input  logic [PIN_IN_W-1:0]  pin_i,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic [PIN_IN_W-1:0]  rx_in0,
    output logic [PIN_IN_W-1:0]  rx_in1,
    output logic [META_W-1:0]    rx_meta
);
    localparam int LAT   = pse_pkg::pin_latency(DDR_MODE);
    localparam int DEPTH = LAT + 2;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int DW    = 2 * PIN_IN_W + META_W;

    logic                fire;
    logic                room;
    logic [CW-1:0]       inflight;
    logic [CW-1:0]       q_count;
    logic                q_full;
    logic                q_push;
    logic                q_pop;
    logic [META_W-1:0]   d_meta;
    logic [PIN_IN_W-1:0] cap0, cap1;
    logic [DW-1:0]       q_dout;

    // Credit check: a capturing beat needs a free slot for its sample.
    assign room     = ({1'b0, q_count} + {1'b0, inflight}) < (CW + 1)'(DEPTH);
    assign tx_ready = !tx_capture || room;
    assign fire     = tx_valid && tx_ready;
    assign q_pop    = rx_ready;

    pse_out_path #(.W(PIN_OUT_W), .DDR(DDR_MODE)) u_out (
        .clk(clk), .rst_n(rst_n), .load(fire),
        .d0(tx_out0), .d1(tx_out1), .oe_in(tx_oe),
        .pin_o(pin_o), .pin_oe(pin_oe)
    );

    pse_in_path #(.W(PIN_IN_W), .DDR(DDR_MODE)) u_in (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .cap0(cap0), .cap1(cap1)
    );

    pse_req_delay #(.MW(META_W), .LAT(LAT), .CW(CW)) u_req (
        .clk(clk), .rst_n(rst_n),
        .req_in(fire && tx_capture), .meta_in(tx_meta),
        .req_out(q_push), .meta_out(d_meta), .inflight(inflight)
    );

    pse_skid_fifo #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_q (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .din({cap1, cap0, d_meta}),
        .pop(q_pop), .dout(q_dout), .valid(rx_valid),
        .count(q_count), .full(q_full)
    );

    assign {rx_in1, rx_in0, rx_meta} = q_dout;
endmodule

// File: rtl/ddr_pin_streamer_chk.sv
`timescale 1ns/1ps
// Protocol and pipeline checks for the pin stream adapter, attached by bind.
module ddr_pin_streamer_chk #(
    parameter int PIN_IN_W = 8,
    parameter int META_W   = 4,
    parameter bit DDR_MODE = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tx_valid,
    input logic                tx_ready,
    input logic                tx_oe,
    input logic                tx_capture,
    input logic                pin_oe,
    input logic                rx_valid,
    input logic                rx_ready,
    input logic [PIN_IN_W-1:0] rx_in0,
    input logic [PIN_IN_W-1:0] rx_in1,
    input logic [META_W-1:0]   rx_meta,
    input logic                q_push,
    input logic                q_pop,
    input logic                q_full
);
    assert_pin_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> pin_oe == $past(tx_oe));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid && tx_ready) |=> $stable(pin_oe));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q_push && q_full |-> q_pop);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_in0)
                                  && $stable(rx_in1) && $stable(rx_meta));

    assert_stall_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |-> tx_capture);

    generate
        if (!DDR_MODE) begin : g_sdr
            assert_sdr_in1_R4: assert property (@(posedge clk) disable iff (!rst_n)
                rx_valid |-> rx_in1 == '0);
        end
    endgenerate
endmodule

bind ddr_pin_streamer ddr_pin_streamer_chk #(
    .PIN_IN_W(PIN_IN_W), .META_W(META_W), .DDR_MODE(DDR_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_oe(tx_oe), .tx_capture(tx_capture), .pin_oe(pin_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_in0(rx_in0),
    .rx_in1(rx_in1), .rx_meta(rx_meta), .q_push(q_push), .q_pop(q_pop),
    .q_full(q_full)
);

// File: tb/ddr_pin_streamer_tb.sv
`timescale 1ns/1ps
module ddr_pin_streamer_tb;
    localparam int OW = 2, IW = 8, MW = 4, MSK = 1023;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [OW-1:0] t0, t1;
    logic          toe, tcap;
    logic [MW-1:0] tmeta;
    logic          tv [2];
    logic          trd [2];
    logic [OW-1:0] po [2];
    logic          poe [2];
    logic [IW-1:0] pin_i;
    logic          rxr;
    logic          rxv [2];
    logic [IW-1:0] r0 [2], r1 [2];
    logic [MW-1:0] rm [2];

    ddr_pin_streamer #(.PIN_OUT_W(OW), .PIN_IN_W(IW), .META_W(MW), .DDR_MODE(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tv[0]), .tx_ready(trd[0]),
        .tx_out0(t0), .tx_out1(t1), .tx_oe(toe), .tx_capture(tcap), .tx_meta(tmeta),
        .pin_o(po[0]), .pin_oe(poe[0]), .pin_i(pin_i),
        .rx_valid(rxv[0]), .rx_ready(rxr), .rx_in0(r0[0]), .rx_in1(r1[0]), .rx_meta(rm[0]));

    ddr_pin_streamer #(.PIN_OUT_W(OW), .PIN_IN_W(IW), .META_W(MW), .DDR_MODE(1'b0)) u_sdr (
        .clk(clk), .rst_n(rst_n), .tx_valid(tv[1]), .tx_ready(trd[1]),
        .tx_out0(t0), .tx_out1(t1), .tx_oe(toe), .tx_capture(tcap), .tx_meta(tmeta),
        .pin_o(po[1]), .pin_oe(poe[1]), .pin_i(pin_i),
        .rx_valid(rxv[1]), .rx_ready(rxr), .rx_in0(r0[1]), .rx_in1(r1[1]), .rx_meta(rm[1]));

    int checks = 0, errors = 0, cyc = 0, stall_mode = 0, stall_cnt = 0;
    logic [IW-1:0] rise_log [1024];
    logic [IW-1:0] fall_log [1024];
    int            ek [2][256];
    logic [MW-1:0] em [2][256];
    int            ewr [2], erd [2], pops [2];
    logic [OW-1:0] lo0 [2], lo1 [2];
    logic          loe [2];
    logic          held [2];
    logic [IW-1:0] p0 [2], p1 [2];
    logic [MW-1:0] pm [2];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Logs of the input pins at each edge, indexed by rising-edge number.
    always @(posedge clk) begin
        rise_log[cyc & MSK] = pin_i;
        cyc = cyc + 1;
    end
    always @(negedge clk) fall_log[(cyc - 1) & MSK] = pin_i;

    // Input pins change a quarter period after every edge.
    initial begin
        pin_i = 8'hA5;
        forever begin
            @(posedge clk); #2.5 pin_i = pin_i - 8'd7;
            @(negedge clk); #2.5 pin_i = pin_i ^ 8'h5C;
        end
    end

    // Receiver: sets ready each falling edge and checks what it will take.
    initial begin
        rxr = 1'b1;
        held[0] = 1'b0; held[1] = 1'b0;
        forever begin
            @(negedge clk);
            rxr = (stall_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
            #1.5;
            for (int s = 0; s < 2; s++) begin
                if (held[s])
                    chk(rxv[s] && r0[s] == p0[s] && r1[s] == p1[s] && rm[s] == pm[s],
                        "R7 held sample changed", int'(r0[s]), int'(p0[s]));
                if (rst_n && rxv[s]) begin
                    if (rxr) begin
                        if (erd[s] == ewr[s]) begin
                            chk(1'b0, "R5 unexpected sample", int'(r0[s]), 0);
                        end else begin
                            int k;
                            k = ek[s][erd[s] & 255];
                            chk(r0[s] == rise_log[k & MSK], "R4 rising sample",
                                int'(r0[s]), int'(rise_log[k & MSK]));
                            chk(r1[s] == ((s == 0) ? fall_log[k & MSK] : 8'h00),
                                "R4 falling sample", int'(r1[s]),
                                (s == 0) ? int'(fall_log[k & MSK]) : 0);
                            chk(rm[s] == em[s][erd[s] & 255], "R6 tag/order",
                                int'(rm[s]), int'(em[s][erd[s] & 255]));
                            erd[s]++;
                            pops[s]++;
                        end
                    end
                    held[s] = !rxr;
                    p0[s] = r0[s]; p1[s] = r1[s]; pm[s] = rm[s];
                end else begin
                    held[s] = 1'b0;
                end
            end
        end
    end

    // Send one beat; entered and left one unit after a falling edge.
    task automatic send(input int sel, input logic [OW-1:0] o0, input logic [OW-1:0] o1,
                        input logic oe, input logic cap, input logic [MW-1:0] meta);
        bit acc;
        int k;
        t0 = o0; t1 = o1; toe = oe; tcap = cap; tmeta = meta;
        tv[sel] = 1'b1;
        acc = 1'b0;
        while (!acc) begin
            #3;
            acc = trd[sel];
            if (!acc) begin
                stall_cnt++;
                chk(cap, "R8 stall of non-capture beat", 0, 1);
            end
            @(posedge clk);
            if (!acc) begin @(negedge clk); #1; end
        end
        #2;
        k = cyc - 1;
        tv[sel] = 1'b0;
        chk(po[sel] == o0, "R1 high-phase pins", int'(po[sel]), int'(o0));
        chk(poe[sel] == oe, "R2 output enable", int'(poe[sel]), int'(oe));
        if (cap) begin
            ek[sel][ewr[sel] & 255] = k;
            em[sel][ewr[sel] & 255] = meta;
            ewr[sel]++;
        end
        lo0[sel] = o0; lo1[sel] = o1; loe[sel] = oe;
        @(negedge clk); #1;
        if (sel == 0) chk(po[0] == o1, "R1 low-phase pins", int'(po[0]), int'(o1));
    endtask

    // Idle cycles: pins and enable must hold their last state.
    task automatic idle(input int sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            chk(po[sel] == lo0[sel] && poe[sel] == loe[sel], "R3 idle hold high",
                int'(po[sel]), int'(lo0[sel]));
            @(negedge clk); #1;
            if (sel == 0) chk(po[0] == lo1[0], "R3 idle hold low", int'(po[0]), int'(lo1[0]));
        end
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0;
        tv[0] = 1'b0; tv[1] = 1'b0;
        t0 = '0; t1 = '0; toe = 1'b0; tcap = 1'b0; tmeta = '0;
        for (int s = 0; s < 2; s++) begin ewr[s] = 0; erd[s] = 0; pops[s] = 0; end
        repeat (3) @(posedge clk);
        #2;
        for (int s = 0; s < 2; s++) begin
            chk(poe[s] == 1'b0 && po[s] == '0, "R9 reset pins", int'(po[s]), 0);
            chk(rxv[s] == 1'b0, "R9 reset rx_valid", int'(rxv[s]), 0);
        end
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(trd[0] && trd[1], "R9 ready after reset", int'(trd[0]), 1);

        // R10: double-rate latency from an empty pipeline.
        send(0, 2'b01, 2'b10, 1'b1, 1'b1, 4'h3);
        chk(!rxv[0], "R10 ddr early", int'(rxv[0]), 0);
        @(negedge clk); #1;
        chk(!rxv[0], "R10 ddr one cycle", int'(rxv[0]), 0);
        @(negedge clk); #1;
        chk(rxv[0], "R10 ddr two cycles", int'(rxv[0]), 1);
        idle(0, 4);

        // R5: alternating capture flag plus one trailing disabled beat.
        base = pops[0];
        for (int i = 0; i < 8; i++)
            send(0, OW'(i), OW'(i + 1), 1'b1, 1'(i % 2), MW'(i));
        send(0, 2'b00, 2'b00, 1'b0, 1'b0, 4'h0);
        idle(0, 8);
        chk(pops[0] - base == 4, "R5 alternating count", pops[0] - base, 4);

        // R1 R2 R4 R6: sweep of pin values, enables, flags and tags.
        for (int i = 0; i < 64; i++)
            send(0, OW'(i), OW'(i >> 2), 1'(i >> 4), (i % 3) != 0, MW'(i ^ (i >> 2)));
        idle(0, 6);

        // R7 R8: receiver stalls force back-pressure.
        stall_mode = 1;
        for (int i = 0; i < 48; i++)
            send(0, OW'(i + 1), OW'(i * 3), 1'(i), (i % 5) != 0, MW'(i * 7));
        idle(0, 30);
        stall_mode = 0;
        idle(0, 5);
        chk(stall_cnt > 0, "R8 back-pressure seen", stall_cnt, 1);

        // Single-rate instance: R10 latency of one cycle, then a sweep.
        send(1, 2'b11, 2'b00, 1'b1, 1'b1, 4'hC);
        chk(!rxv[1], "R10 sdr early", int'(rxv[1]), 0);
        @(negedge clk); #1;
        chk(rxv[1], "R10 sdr one cycle", int'(rxv[1]), 1);
        idle(1, 3);
        for (int i = 0; i < 32; i++)
            send(1, OW'(i), OW'(~i), 1'(i >> 1), (i % 2) == 0, MW'(i));
        idle(1, 6);

        for (int s = 0; s < 2; s++)
            chk(erd[s] == ewr[s], "R5 all samples returned", erd[s], ewr[s]);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule